// File: doc/BRIEF.md
# Remote Reset and Power-Off Control Register

This block is a two-bit control register that a host bus controller writes to request two board-level actions. The first is a timed remote reset: writing a one to the trigger bit starts a pulse that drives an active-low reset output for a fixed minimum time measured in microsecond timebase ticks. The trigger bit clears itself when the pulse is over. The second is a remote power-off request: writing a one to the power-off bit sets a latch that drives the power-off output high. Only the system reset input can release this latch.

The system reset input is active low and reports that main system power has been removed. While it is low, the block clears the power-off latch, forces the fan-speed code passed through it to zero, and raises a clear request for the limit-lock bit held elsewhere. The bus protocol and the pad drivers are outside the block. The host sees a one-cycle write strobe with a data byte, and reads the register state back as a byte.

The reset pulse is sequenced by a two-state machine. `PS_IDLE` leaves the reset output released. The transition *trigger* (a write with bit 0 set) clears the tick counter and moves to `PS_LOW`. `PS_LOW` drives the reset output low and counts timebase ticks. The transition *expire* (the tick after the counter has reached the configured width) returns to `PS_IDLE`. A trigger that arrives in `PS_LOW` causes no transition.

Top module: `remote_power_ctl`

## Requirements
- R1: After power-on reset the readback byte is 00h, the reset output is high and the power-off output is low.
- R2: A write with bit 0 set drives the reset output low for at least WIDTH_TICKS (125) tick periods, and for no more than WIDTH_TICKS+1 tick periods.
- R3: Readback bit 0 reads 1 while the reset pulse is in progress and reads 0 once the reset output has returned high.
- R4: A write with bit 0 set during a pulse is ignored: it neither restarts nor lengthens the pulse.
- R5: A write with bit 1 set drives the power-off output high and readback bit 1 to 1. Both stay set through later writes while the system reset input is high.
- R6: The system reset input held low clears the power-off latch at the next clock. While it stays low, a write with bit 1 set cannot set the latch.
- R7: Writing 0 to bit 0 or bit 1 has no effect on either output or on the readback byte.
- R8: Readback bits 7 to 2 always read 0, whatever value was written to them.
- R9: While the system reset input is low, the fan-speed code output is 0 and the lock-clear output is 1. Otherwise the fan-speed code output equals its input and the lock-clear output is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| por_n | input | 1 | Power-on reset, active low, asynchronous |
| sys_rst_n | input | 1 | System-power-removed input, active low |
| wr_en | input | 1 | One-cycle register write strobe |
| wr_data | input | DATA_W | Write data; bit 0 triggers reset, bit 1 requests power-off |
| tick_us | input | 1 | One-cycle microsecond timebase tick |
| fan_code_in | input | FAN_W | Fan-speed code from the control path |
| rrst_n | output | 1 | Remote reset output, active low |
| poff | output | 1 | Remote power-off output, active high |
| rd_data | output | DATA_W | Readback byte: {reserved zeros, power-off, pulse busy} |
| fan_code_out | output | FAN_W | Fan-speed code, forced to zero during system reset |
| lock_clear | output | 1 | Request to clear the limit-lock bit |

## Verification
A state machine stuck in `PS_LOW` leaves the reset output low and readback bit 0 set past WIDTH_TICKS+1 ticks. The first readback after the window shows it. A counter that restarts on a second trigger lengthens the low time beyond the upper bound within one pulse. A power-off latch that ignores the system reset input, or one that can be set while that input is low, shows a wrong output level one clock after the stimulus. A missing fan gate shows at once on the fan-speed code output.

// File: rtl/remote_power_pkg.sv
package remote_power_pkg;

    localparam int BIT_RESET = 0;
    localparam int BIT_POFF  = 1;
    localparam int NUM_CTRL  = 2;

    typedef enum logic [0:0] {
        PS_IDLE = 1'b0,
        PS_LOW  = 1'b1
    } pulse_state_e;

endpackage

// File: rtl/rpc_pulse_timer.sv
module rpc_pulse_timer
    import remote_power_pkg::*;
#(
    parameter int WIDTH_TICKS = 125
) (
    input  logic clk,
    input  logic por_n,
    input  logic trig,
    input  logic tick_us,
    output logic pin_n,
    output logic busy
);

    localparam int CW = $clog2(WIDTH_TICKS + 1);
    localparam logic [CW-1:0] LAST = CW'(WIDTH_TICKS);

    pulse_state_e state_q;
    logic [CW-1:0] cnt_q;

    // State register and tick counter
    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) begin
            state_q <= PS_IDLE;
            cnt_q   <= '0;
        end else begin
            unique case (state_q)
                PS_IDLE: begin
                    if (trig) begin
                        state_q <= PS_LOW;
                        cnt_q   <= '0;
                    end
                end
                PS_LOW: begin
                    // a trigger here is ignored: counter is not reloaded
                    if (tick_us) begin
                        if (cnt_q == LAST) begin
                            state_q <= PS_IDLE;
                        end else begin
                            cnt_q <= cnt_q + 1'b1;
                        end
                    end
                end
                default: state_q <= PS_IDLE;
            endcase
        end
    end

    // Outputs from state
    always_comb begin
        unique case (state_q)
            PS_LOW:  begin pin_n = 1'b0; busy = 1'b1; end
            default: begin pin_n = 1'b1; busy = 1'b0; end
        endcase
    end

    // Checker: ticks observed while the pin is low
    int ck_ticks;
    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) begin
            ck_ticks <= 0;
        end else if (pin_n) begin
            ck_ticks <= 0;
        end else if (tick_us) begin
            ck_ticks <= ck_ticks + 1;
        end
    end

    assert_min_width_R2: assert property (@(posedge clk) disable iff (!por_n)
        $rose(pin_n) |-> (ck_ticks >= WIDTH_TICKS))
        else $error("reset pulse shorter than minimum width");

    assert_max_width_R2: assert property (@(posedge clk) disable iff (!por_n)
        !pin_n |-> (ck_ticks <= WIDTH_TICKS + 1))
        else $error("reset pulse longer than maximum width");

    assert_no_retrigger_R4: assert property (@(posedge clk) disable iff (!por_n)
        (!pin_n && trig && !tick_us) |=> $stable(cnt_q))
        else $error("retrigger disturbed the pulse counter");

endmodule

// File: rtl/rpc_poff_latch.sv
module rpc_poff_latch (
    input  logic clk,
    input  logic por_n,
    input  logic sys_rst_n,
    input  logic set_req,
    output logic poff
);

    logic poff_q;

    // System reset low has priority over a set request
    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) begin
            poff_q <= 1'b0;
        end else if (!sys_rst_n) begin
            poff_q <= 1'b0;
        end else if (set_req) begin
            poff_q <= 1'b1;
        end
    end

    assign poff = poff_q;

    assert_poff_hold_R5: assert property (@(posedge clk) disable iff (!por_n)
        (poff && sys_rst_n) |=> poff)
        else $error("power-off latch released without system reset");

    assert_poff_clear_R6: assert property (@(posedge clk) disable iff (!por_n)
        !sys_rst_n |=> !poff)
        else $error("power-off latch not cleared by system reset");

endmodule

// File: rtl/rpc_fan_gate.sv
module rpc_fan_gate #(
    parameter int FAN_W = 8
) (
    input  logic             sys_rst_n,
    input  logic [FAN_W-1:0] fan_code_in,
    output logic [FAN_W-1:0] fan_code_out,
    output logic             lock_clear
);

    // R9: fan forced off and lock release requested while system power is removed
    always_comb begin
        if (!sys_rst_n) begin
            fan_code_out = '0;
            lock_clear   = 1'b1;
        end else begin
            fan_code_out = fan_code_in;
            lock_clear   = 1'b0;
        end
    end

endmodule

// File: rtl/remote_power_ctl.sv
module remote_power_ctl
    import remote_power_pkg::*;
#(
    parameter int DATA_W      = 8,
    parameter int FAN_W       = 8,
    parameter int WIDTH_TICKS = 125
) (
    input  logic              clk,
    input  logic              por_n,
    input  logic              sys_rst_n,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              tick_us,
    input  logic [FAN_W-1:0]  fan_code_in,
    output logic              rrst_n,
    output logic              poff,
    output logic [DATA_W-1:0] rd_data,
    output logic [FAN_W-1:0]  fan_code_out,
    output logic              lock_clear
);

    localparam int RSVD_W = DATA_W - NUM_CTRL;

    logic trig;
    logic set_req;
    logic busy;
    logic unused_rsvd;

    // Writing 0 to a control bit does nothing (R7)
    assign trig        = wr_en & wr_data[BIT_RESET];
    assign set_req     = wr_en & wr_data[BIT_POFF];
    assign unused_rsvd = ^wr_data[DATA_W-1:NUM_CTRL];

    rpc_pulse_timer #(
        .WIDTH_TICKS (WIDTH_TICKS)
    ) u_pulse (
        .clk     (clk),
        .por_n   (por_n),
        .trig    (trig),
        .tick_us (tick_us),
        .pin_n   (rrst_n),
        .busy    (busy)
    );

    rpc_poff_latch u_poff (
        .clk       (clk),
        .por_n     (por_n),
        .sys_rst_n (sys_rst_n),
        .set_req   (set_req),
        .poff      (poff)
    );

    rpc_fan_gate #(
        .FAN_W (FAN_W)
    ) u_fan (
        .sys_rst_n    (sys_rst_n),
        .fan_code_in  (fan_code_in),
        .fan_code_out (fan_code_out),
        .lock_clear   (lock_clear)
    );

    // Readback: reserved bits zero (R8)
    assign rd_data = {{RSVD_W{1'b0}}, poff, busy};

    assert_busy_matches_pin_R3: assert property (@(posedge clk) disable iff (!por_n)
        rd_data[BIT_RESET] == !rrst_n)
        else $error("readback bit 0 disagrees with reset pin");

endmodule

// File: tb/remote_power_ctl_tb.sv
`timescale 1ns/1ps
module remote_power_ctl_tb;

    localparam int W     = 125;
    localparam int TDIV  = 50;
    localparam int LO_MIN = W * TDIV;
    localparam int LO_MAX = (W + 1) * TDIV + 2;

    logic       clk = 1'b0;
    logic       por_n = 1'b0;
    logic       sys_rst_n = 1'b1;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = 8'h00;
    logic       tick_us = 1'b0;
    logic [7:0] fan_code_in = 8'hA5;
    logic       rrst_n, poff, lock_clear;
    logic [7:0] rd_data, fan_code_out;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    typedef struct {
        string      req;
        logic [7:0] rd;
        logic       rr;
        logic       po;
    } exp_t;
    exp_t sb_q[$];

    always #10 clk = ~clk;

    remote_power_ctl u_dut (
        .clk          (clk),
        .por_n        (por_n),
        .sys_rst_n    (sys_rst_n),
        .wr_en        (wr_en),
        .wr_data      (wr_data),
        .tick_us      (tick_us),
        .fan_code_in  (fan_code_in),
        .rrst_n       (rrst_n),
        .poff         (poff),
        .rd_data      (rd_data),
        .fan_code_out (fan_code_out),
        .lock_clear   (lock_clear)
    );

    // 1 us timebase
    int tdiv = 0;
    always @(negedge clk) begin
        tdiv    <= (tdiv == TDIV - 1) ? 0 : tdiv + 1;
        tick_us <= (tdiv == TDIV - 1);
    end

    task automatic check(input string req, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // Scoreboard monitor
    always @(negedge clk) begin
        if (sb_q.size() > 0) begin
            exp_t e;
            e = sb_q.pop_front();
            check({e.req, " rd_data"}, rd_data, e.rd);
            check({e.req, " rrst_n"}, rrst_n, e.rr);
            check({e.req, " poff"}, poff, e.po);
        end
    end

    task automatic expect_state(input string req, input logic [7:0] rd,
                                input logic rr, input logic po);
        exp_t e;
        e.req = req; e.rd = rd; e.rr = rr; e.po = po;
        sb_q.push_back(e);
        @(negedge clk);
        #1;
    endtask

    task automatic write_reg(input logic [7:0] d);
        @(negedge clk);
        wr_en   = 1'b1;
        wr_data = d;
        @(negedge clk);
        wr_en   = 1'b0;
        wr_data = 8'h00;
    endtask

    // Starts a pulse (state must be idle) and returns the low time in clocks
    task automatic pulse_run(input logic [7:0] d, input int retrig_at,
                             output int low_clks);
        write_reg(d);
        low_clks = 0;
        while (rrst_n == 1'b0 && low_clks < 20000) begin
            low_clks++;
            if (low_clks == 10) check("R3 bit0 busy", rd_data[0], 1);
            if (low_clks == retrig_at) begin
                wr_en = 1'b1; wr_data = 8'h01;
            end else begin
                wr_en = 1'b0; wr_data = 8'h00;
            end
            @(negedge clk);
        end
        wr_en = 1'b0;
    endtask

    initial begin
        int lo;
        repeat (4) @(negedge clk);
        por_n = 1'b1;
        @(negedge clk);
        expect_state("R1 reset", 8'h00, 1'b1, 1'b0);

        write_reg(8'h00);
        expect_state("R7 write zero", 8'h00, 1'b1, 1'b0);

        write_reg(8'hFC);
        expect_state("R8 reserved only", 8'h00, 1'b1, 1'b0);

        pulse_run(8'h01, 0, lo);
        check("R2 low >= min", (lo >= LO_MIN) ? 1 : 0, 1);
        check("R2 low <= max", (lo <= LO_MAX) ? 1 : 0, 1);
        expect_state("R3 self clear", 8'h00, 1'b1, 1'b0);

        pulse_run(8'h01, 3000, lo);
        check("R4 retrigger low >= min", (lo >= LO_MIN) ? 1 : 0, 1);
        check("R4 retrigger not stretched", (lo <= LO_MAX) ? 1 : 0, 1);
        expect_state("R4 after retrigger", 8'h00, 1'b1, 1'b0);

        write_reg(8'h02);
        expect_state("R5 set poff", 8'h02, 1'b1, 1'b1);
        write_reg(8'h00);
        expect_state("R7 poff kept", 8'h02, 1'b1, 1'b1);
        write_reg(8'hFC);
        expect_state("R8 reserved read zero", 8'h02, 1'b1, 1'b1);
        pulse_run(8'h01, 0, lo);
        check("R2 low >= min with poff", (lo >= LO_MIN) ? 1 : 0, 1);
        expect_state("R5 poff survives pulse", 8'h02, 1'b1, 1'b1);

        check("R9 fan pass", fan_code_out, 8'hA5);
        check("R9 lock idle", lock_clear, 0);
        @(negedge clk);
        sys_rst_n = 1'b0;
        #1;
        check("R9 fan forced off", fan_code_out, 8'h00);
        check("R9 lock clear req", lock_clear, 1);
        expect_state("R6 poff cleared", 8'h00, 1'b1, 1'b0);
        write_reg(8'h02);
        expect_state("R6 set blocked", 8'h00, 1'b1, 1'b0);
        sys_rst_n = 1'b1;
        fan_code_in = 8'h3C;
        #1;
        check("R9 fan restored", fan_code_out, 8'h3C);
        check("R9 lock released", lock_clear, 0);

        write_reg(8'hFF);
        expect_state("R8 write FF", 8'h03, 1'b0, 1'b1);
        while (rrst_n == 1'b0) @(negedge clk);
        expect_state("R3 clear after FF", 8'h02, 1'b1, 1'b1);

        por_n = 1'b0;
        @(negedge clk);
        por_n = 1'b1;
        expect_state("R1 re-reset", 8'h00, 1'b1, 1'b0);

        repeat (3) @(negedge clk);
        done = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

endmodule